// File: doc/BRIEF.md
# Multi-ratio peripheral register bridge

The bridge carries single CPU read and write requests to a bank of on-chip peripheral registers through three clock domains of related rate: a fast core rate, a mid-rate internal bus and a slow peripheral bus. All three run from one fast clock. The two slower rates are free-running clock enables with integer division ratios set by parameters. The fast rate must be at least the bus rate, and the bus rate at least the peripheral rate. The default ratio is 4:2:1, and 4:2:2 is also supported.

An accepted request moves through the stages in a fixed order. It spends a fixed number of fast cycles on the CPU side and then waits for the next bus tick. It spends at least one bus cycle on the internal bus and then waits for the next peripheral tick. The register access then takes two peripheral cycles. A read adds a two-cycle return trip back to the CPU side. Because of the alignment waits, the total latency depends on the phase of the enables at the moment of acceptance. A small register file on the peripheral side acts as the target.

Top module: `periph_bridge`

## Requirements
- R1: After reset `busy`, `done` and `rdata` are 0, and every register reads as 0.
- R2: A request (`req_valid` high) is accepted on a clock edge where `busy` is low. `busy` is high from the cycle after acceptance through the cycle of the completing edge. `busy` is low in the cycle that shows `done`.
- R3: Fast clock edges are numbered from 1 after reset release. Bus ticks are the edges divisible by BUS_DIV. A request accepted at edge e0 enters the bus stage at the first bus tick at or after e0+3, so the CPU-side phase is 3+n fast cycles with 0 <= n < BUS_DIV.
- R4: Peripheral ticks are the edges divisible by PER_DIV. They always coincide with bus ticks. A request that enters the bus stage at edge eA moves to the peripheral stage at the first peripheral tick at or after eA+BUS_DIV, so this phase is (1+m) bus cycles.
- R5: A write completes 2*PER_DIV fast cycles after it enters the peripheral stage. Its latency from the accepting edge to the edge that raises `done` is 3+n + BUS_DIV*(1+m) + 2*PER_DIV.
- R6: A read has the write latency plus 2 fast cycles.
- R7: On a write, bit i of `req_strb` enables byte i (bits 8i+7..8i) of the register. Bytes whose strobe is 0 keep their old value.
- R8: The register index is `req_addr[5:2]`, which selects one of 16 words; the other address bits are ignored. On a read, `rdata` equals that register's contents in the cycle where `done` is high.
- R9: Requests presented while `busy` is high are ignored: they change no register and produce no `done`.
- R10: `done` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| req_strb | input | 4 | Byte enables for writes |
| busy | output | 1 | Request in flight |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Read data, valid when done is high |

## Verification
The hardest situations to reach are the alignment waits. The values of n and m depend only on where acceptance falls relative to two free-running enables that the ports do not show. The bench inserts a random idle gap of 0 to 7 cycles before each request so that every acceptance phase occurs. It derives n and m from its own edge count and requires that every value of both was seen. Ignored requests are injected in the cycle just after acceptance, and a later read-back of the targeted register reveals whether they had any effect.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CPU,
        ST_BUS,
        ST_PER,
        ST_RET
    } stage_e;
endpackage

// File: rtl/bridge_clk_en.sv
module bridge_clk_en #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_full
            assign tick = 1'b1;
        end else begin : g_cnt
            localparam int W = $clog2(DIV);
            logic [W-1:0] cnt_d, cnt_q;
            always_comb begin
                cnt_d = (cnt_q == W'(DIV - 1)) ? '0 : cnt_q + 1'b1;
            end
            always_ff @(posedge clk) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end
            assign tick = (cnt_q == W'(DIV - 1));
        end
    endgenerate
endmodule

// File: rtl/bridge_regfile.sv
module bridge_regfile #(
    parameter int DATA_W = 32,
    parameter int NREGS  = 16,
    localparam int IDX_W  = $clog2(NREGS),
    localparam int STRB_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STRB_W-1:0] strb,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem_d [NREGS];
    logic [DATA_W-1:0] mem_q [NREGS];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            for (int b = 0; b < STRB_W; b++) begin
                if (strb[b]) mem_d[idx][b*8 +: 8] = wdata[b*8 +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= '{default: '0};
        else        mem_q <= mem_d;
    end

    assign rd_data = mem_q[idx];
endmodule

// File: rtl/periph_bridge.sv
module periph_bridge
    import bridge_pkg::*;
#(
    parameter int BUS_DIV = 2,
    parameter int PER_DIV = 4,
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int NREGS   = 16,
    localparam int STRB_W = DATA_W / 8,
    localparam int IDX_W  = $clog2(NREGS),
    localparam int CNT_W  = $clog2(BUS_DIV + 3) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [STRB_W-1:0] req_strb,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        stage_e            stage;
        logic [CNT_W-1:0]  wait_cnt;
        logic              per_cnt;
        logic              is_write;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] wdata;
        logic [STRB_W-1:0] strb;
        logic              done;
        logic [DATA_W-1:0] rdata;
    } bridge_st_t;

    bridge_st_t        s_d, s_q;
    logic              bus_tick, per_tick;
    logic              wr_en;
    logic [DATA_W-1:0] rd_data;
    logic [CNT_W-1:0]  wait_inc;

    initial begin
        ratio_cfg_chk: assert (PER_DIV % BUS_DIV == 0 && BUS_DIV >= 1);
    end

    bridge_clk_en #(.DIV(BUS_DIV)) bus_en_i (.clk(clk), .rst_n(rst_n), .tick(bus_tick));
    bridge_clk_en #(.DIV(PER_DIV)) per_en_i (.clk(clk), .rst_n(rst_n), .tick(per_tick));

    bridge_regfile #(.DATA_W(DATA_W), .NREGS(NREGS)) regs_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .idx    (s_q.idx),
        .wdata  (s_q.wdata),
        .strb   (s_q.strb),
        .rd_data(rd_data)
    );

    assign wait_inc = (s_q.wait_cnt == '1) ? s_q.wait_cnt : s_q.wait_cnt + 1'b1;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        wr_en    = 1'b0;
        case (s_q.stage)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.stage    = ST_CPU;
                    s_d.wait_cnt = '0;
                    s_d.is_write = req_write;
                    s_d.idx      = req_addr[2 +: IDX_W];
                    s_d.wdata    = req_wdata;
                    s_d.strb     = req_strb;
                end
            end
            ST_CPU: begin
                if (s_q.wait_cnt >= CNT_W'(2) && bus_tick) begin
                    s_d.stage    = ST_BUS;
                    s_d.wait_cnt = '0;
                end else begin
                    s_d.wait_cnt = wait_inc;
                end
            end
            ST_BUS: begin
                if (s_q.wait_cnt >= CNT_W'(BUS_DIV - 1) && per_tick) begin
                    s_d.stage   = ST_PER;
                    s_d.per_cnt = 1'b0;
                end else begin
                    s_d.wait_cnt = wait_inc;
                end
            end
            ST_PER: begin
                if (per_tick) begin
                    if (s_q.per_cnt) begin
                        if (s_q.is_write) begin
                            wr_en       = 1'b1;
                            s_d.done    = 1'b1;
                            s_d.stage   = ST_IDLE;
                        end else begin
                            s_d.rdata    = rd_data;
                            s_d.stage    = ST_RET;
                            s_d.wait_cnt = '0;
                        end
                    end else begin
                        s_d.per_cnt = 1'b1;
                    end
                end
            end
            ST_RET: begin
                if (s_q.wait_cnt >= CNT_W'(1)) begin
                    s_d.done  = 1'b1;
                    s_d.stage = ST_IDLE;
                end else begin
                    s_d.wait_cnt = wait_inc;
                end
            end
            default: s_d.stage = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.stage <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy  = (s_q.stage != ST_IDLE);
    assign done  = s_q.done;
    assign rdata = s_q.rdata;

    logic in_bus, in_per;
    assign in_bus = (s_q.stage == ST_BUS);
    assign in_per = (s_q.stage == ST_PER);

    // R2
    busy_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

    // R3
    bus_handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_bus) |-> $past(bus_tick));

    // R4
    per_handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_per) |-> $past(per_tick));

    // R4
    per_on_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_tick |-> bus_tick);

    // R9
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(s_q.idx) && $stable(s_q.wdata) && $stable(s_q.is_write)));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/periph_bridge_tb_top.sv
module periph_bridge_tb_top;
    localparam int BUS_DIV = 2;
    localparam int PER_DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_strb = '0;
    logic        busy, done;
    logic [31:0] rdata;

    int          ecnt = 0;
    int          errors = 0;
    int          checks = 0;
    logic [31:0] model [16];
    int          n_hit [4];
    int          m_hit [4];

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) ecnt <= 0;
        else        ecnt <= ecnt + 1;
    end

    periph_bridge #(.BUS_DIV(BUS_DIV), .PER_DIV(PER_DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_strb(req_strb),
        .busy(busy), .done(done), .rdata(rdata)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int calc_n(input int e0);
        return (BUS_DIV - ((e0 + 3) % BUS_DIV)) % BUS_DIV;
    endfunction

    function automatic int calc_m(input int e0);
        int ea, eb;
        ea = e0 + 3 + calc_n(e0);
        eb = ea + BUS_DIV;
        while (eb % PER_DIV != 0) eb++;
        return (eb - ea - BUS_DIV) / BUS_DIV;
    endfunction

    function automatic int calc_lat(input int e0, input bit wr);
        int l;
        l = 3 + calc_n(e0) + BUS_DIV * (1 + calc_m(e0)) + 2 * PER_DIV;
        return wr ? l : l + 2;
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                          input logic [3:0] st);
        logic [31:0] r;
        r = old;
        for (int b = 0; b < 4; b++) if (st[b]) r[b*8 +: 8] = nw[b*8 +: 8];
        return r;
    endfunction

    task automatic access(input bit wr, input logic [31:0] addr, input logic [31:0] wd,
                          input logic [3:0] st, input bit inject);
        int e0, ed, lat, idx;
        bit got;
        idx = int'(addr[5:2]);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd; req_strb = st;
        @(negedge clk);
        e0 = ecnt;
        req_valid = 1'b0;
        chk(busy == 1'b1, "R2 busy after accept", busy, 1);
        if (inject) begin
            // R9: request during busy, must have no effect
            req_valid = 1'b1; req_write = 1'b1; req_addr = {26'h3a5, addr[5:2] ^ 4'h1, 2'b00};
            req_wdata = ~wd; req_strb = 4'hF;
            @(negedge clk);
            req_valid = 1'b0;
        end
        got = 1'b0;
        for (int k = 0; k < 400; k++) begin
            if (done) begin got = 1'b1; break; end
            @(negedge clk);
        end
        chk(got, "R10 done seen", got, 1);
        ed  = ecnt;
        lat = ed - e0;
        n_hit[calc_n(e0)]++;
        m_hit[calc_m(e0)]++;
        if (wr) chk(lat == calc_lat(e0, 1'b1), "R5 write latency", lat, calc_lat(e0, 1'b1));
        else    chk(lat == calc_lat(e0, 1'b0), "R6 read latency", lat, calc_lat(e0, 1'b0));
        chk(busy == 1'b0, "R2 busy low on done", busy, 0);
        if (wr) model[idx] = merge(model[idx], wd, st);
        else    chk(rdata == model[idx], "R8 read data", rdata, model[idx]);
        @(negedge clk);
        chk(done == 1'b0, "R10 single pulse", done, 0);
    endtask

    initial begin
        void'($urandom(32'd2718));
        for (int i = 0; i < 16; i++) model[i] = '0;
        for (int i = 0; i < 4; i++) begin n_hit[i] = 0; m_hit[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(busy == 1'b0, "R1 busy reset", busy, 0);
        chk(done == 1'b0, "R1 done reset", done, 0);
        chk(rdata == 32'h0, "R1 rdata reset", rdata, 0);
        access(1'b0, 32'h0000_0014, 32'h0, 4'h0, 1'b0);
        chk(rdata == 32'h0, "R1 register reset value", rdata, 0);
        // R7 partial strobes
        access(1'b1, 32'h0000_0008, 32'hA1B2_C3D4, 4'hF, 1'b0);
        access(1'b1, 32'h0000_0008, 32'h1122_3344, 4'b0101, 1'b0);
        access(1'b0, 32'h0000_0008, 32'h0, 4'h0, 1'b0);
        chk(rdata == 32'hA122_C344, "R7 byte strobes", rdata, 32'hA122_C344);
        // R8 upper address bits ignored
        access(1'b1, 32'hFFFF_FFFC, 32'hCAFE_F00D, 4'hF, 1'b0);
        access(1'b0, 32'h0000_003C, 32'h0, 4'h0, 1'b0);
        chk(rdata == 32'hCAFE_F00D, "R8 alias index", rdata, 32'hCAFE_F00D);
        // R9 directed: write while busy to the neighbour register
        access(1'b1, 32'h0000_0004, 32'h5555_AAAA, 4'hF, 1'b1);
        access(1'b0, 32'h0000_0000, 32'h0, 4'h0, 1'b0);
        chk(rdata == model[0], "R9 ignored while busy", rdata, model[0]);
        for (int t = 0; t < 250; t++) begin
            int gap;
            gap = int'($urandom_range(0, 7));
            repeat (gap) @(negedge clk);
            access(1'($urandom_range(0, 1)), $urandom, $urandom, 4'($urandom),
                   ($urandom_range(0, 7) == 0));
        end
        for (int i = 0; i < 16; i++)
            access(1'b0, 32'(i * 4), 32'h0, 4'h0, 1'b0);
        for (int i = 0; i < BUS_DIV; i++)
            chk(n_hit[i] > 0, "R3 n value reached", n_hit[i], 1);
        for (int i = 0; i < PER_DIV / BUS_DIV; i++)
            chk(m_hit[i] > 0, "R4 m value reached", m_hit[i], 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule